// File: doc/BRIEF.md
# Color Fill Write Controller

This block sits in front of the write port of a 16-bit frame-buffer memory model and turns decoded fill requests into one column write per clock. It keeps a 16-bit color register and a per-bit I/O write mask. Three fill-related operations are offered. A block write paints the color into an aligned group of eight columns, gated per byte lane by a column mask. A flash write paints the color into every column of the open row. Load and read operations give access to the color register itself.

A row cycle is opened with a row request. It latches the row address and, when masked mode is requested, takes the I/O mask from the data bus; otherwise the mask becomes all ones. That mask then governs every block and flash write until the next row request. Every write the block issues carries per-bit enables, so masked bits keep their stored value in the memory.

Top module: `color_fill_ctrl`

## Requirements
- R1: After reset, busy, mem_we and rd_valid are 0, the color register reads 16'hFFFF and the I/O mask is all ones (a flash write with no row request enables all 16 bits, on row 0).
- R2: An accepted row request (req_op 1) latches req_row. With req_masked=1 the I/O mask becomes req_data; with req_masked=0 it becomes all ones.
- R3: An accepted block write (req_op 2) presents columns {req_col_grp, k} for k = 0 to 7 in that order, column k in the k-th cycle after the accepting edge, each carrying the color register on mem_wdata and the open row on mem_row.
- R4: In a block write, req_data bit k gates column k for bits 7..0, and bit 8+k gates column k for bits 15..8. The bit enables are that lane gate ANDed with the I/O mask.
- R5: mem_we is 1 exactly in sweep cycles whose bit enables are not all zero. It stays 0 during load and read of the color register, so the addressed row is left untouched.
- R6: An accepted flash write (req_op 3) presents columns 0 to 511 in ascending order, one per cycle, with bit enables equal to the I/O mask and data equal to the color register.
- R7: busy is 1 for exactly 8 cycles after a block write and 512 cycles after a flash write. Any request made while busy is 1 is dropped with no effect.
- R8: After an accepted load request (req_op 4), the color register takes req_data in the cycle in which the later of cas_fall and we_fall has been seen; both may occur in the same cycle. busy stays 1 from the request until that cycle.
- R9: An accepted read request (req_op 5) gives rd_valid=1 for one cycle, with rd_data equal to the color register, in the cycle after acceptance.
- R10: The I/O mask set by a row request stays in force for every block and flash write that follows it, until the next row request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled when busy is 0 |
| req_op | input | 3 | 1 row, 2 block, 3 flash, 4 load color, 5 read color |
| req_masked | input | 1 | Masked row cycle select (row request) |
| req_row | input | 9 | Row address (row request) |
| req_col_grp | input | 6 | Column group, upper column bits (block write) |
| req_data | input | 16 | Data bus: I/O mask, column mask or color data |
| cas_fall | input | 1 | Column strobe falling-edge pulse |
| we_fall | input | 1 | Write strobe falling-edge pulse |
| busy | output | 1 | Sweep or color load in progress |
| mem_we | output | 1 | Memory write strobe |
| mem_row | output | 9 | Memory row address |
| mem_col | output | 9 | Memory column address |
| mem_wdata | output | 16 | Memory write data |
| mem_bit_en | output | 16 | Memory per-bit write enables |
| rd_valid | output | 1 | Color read result valid |
| rd_data | output | 16 | Color read result |

## Verification
A request is accepted on a rising edge. Column k of a sweep is visible in the cycle that follows edge k after acceptance, and busy is low in the cycle after the final column. A read result is due one cycle after acceptance. A new color value is visible on a read issued in any cycle after the completing strobe. The bench drives inputs on the falling edge and samples each port at the next falling edge, so every expected column, mask and color value is compared in exactly the cycle it is due. Reference values come from bench functions that track the row, mask and color.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_ROW   = 3'd1,
    OP_BLOCK = 3'd2,
    OP_FLASH = 3'd3,
    OP_LOADC = 3'd4,
    OP_READC = 3'd5
  } cfc_op_e;
endpackage

// File: rtl/cfc_color_reg.sv
module cfc_color_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              cas_fall,
  input  logic              we_fall,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] color,
  output logic              pending
);
  logic              pend_q, pend_d;
  logic              cas_q, cas_d;
  logic              we_q, we_d;
  logic [DATA_W-1:0] color_q;
  logic              color_en;
  logic              cas_now, we_now;

  assign cas_now  = cas_q | cas_fall;
  assign we_now   = we_q | we_fall;
  // later of the two strobes completes the load
  assign color_en = pend_q & cas_now & we_now;

  always_comb begin
    pend_d = pend_q;
    cas_d  = cas_q;
    we_d   = we_q;
    if (arm) begin
      pend_d = 1'b1;
      cas_d  = 1'b0;
      we_d   = 1'b0;
    end else if (color_en) begin
      pend_d = 1'b0;
      cas_d  = 1'b0;
      we_d   = 1'b0;
    end else if (pend_q) begin
      cas_d = cas_now;
      we_d  = we_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cas_q  <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      cas_q  <= cas_d;
      we_q   <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      color_q <= '1;
    end else if (color_en) begin
      color_q <= din;
    end
  end

  assign color   = color_q;
  assign pending = pend_q;
endmodule

// File: rtl/cfc_sweep.sv
module cfc_sweep #(
  parameter int COL_W = 9,
  parameter int BLK_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_blk,
  input  logic                   start_fl,
  input  logic [COL_W-BLK_W-1:0] grp,
  output logic                   active,
  output logic                   is_blk,
  output logic [COL_W-1:0]       col,
  output logic [BLK_W-1:0]       sub
);
  localparam int GRP_W = COL_W - BLK_W;

  logic             act_q, act_d;
  logic             blk_q, blk_d;
  logic [COL_W-1:0] cnt_q, cnt_d;
  logic [GRP_W-1:0] grp_q;
  logic             grp_en;
  logic             last;

  assign last   = blk_q ? (&cnt_q[BLK_W-1:0]) : (&cnt_q);
  assign grp_en = start_blk;

  always_comb begin
    act_d = act_q;
    blk_d = blk_q;
    cnt_d = cnt_q;
    if (start_blk || start_fl) begin
      act_d = 1'b1;
      blk_d = start_blk;
      cnt_d = '0;
    end else if (act_q) begin
      cnt_d = cnt_q + 1'b1;
      if (last) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      blk_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      blk_q <= blk_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= '0;
    end else if (grp_en) begin
      grp_q <= grp;
    end
  end

  assign active = act_q;
  assign is_blk = blk_q;
  assign sub    = cnt_q[BLK_W-1:0];
  assign col    = blk_q ? {grp_q, cnt_q[BLK_W-1:0]} : cnt_q;
endmodule

// File: rtl/cfc_lane_mask.sv
module cfc_lane_mask #(
  parameter int DATA_W   = 16,
  parameter int BLK_COLS = 8
) (
  input  logic [DATA_W-1:0]           cmask,
  input  logic [$clog2(BLK_COLS)-1:0] sel,
  output logic [DATA_W-1:0]           lane_en
);
  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [BLK_COLS-1:0] seg;
    assign seg = cmask[ln*BLK_COLS +: BLK_COLS];
    assign lane_en[ln*LANE_W +: LANE_W] = {LANE_W{seg[sel]}};
  end
endmodule

// File: rtl/color_fill_ctrl.sv
module color_fill_ctrl #(
  parameter int ROW_W    = 9,
  parameter int COL_W    = 9,
  parameter int DATA_W   = 16,
  parameter int BLK_COLS = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  input  logic [2:0]                           req_op,
  input  logic                                 req_masked,
  input  logic [ROW_W-1:0]                     req_row,
  input  logic [COL_W-$clog2(BLK_COLS)-1:0]    req_col_grp,
  input  logic [DATA_W-1:0]                    req_data,
  input  logic                                 cas_fall,
  input  logic                                 we_fall,
  output logic                                 busy,
  output logic                                 mem_we,
  output logic [ROW_W-1:0]                     mem_row,
  output logic [COL_W-1:0]                     mem_col,
  output logic [DATA_W-1:0]                    mem_wdata,
  output logic [DATA_W-1:0]                    mem_bit_en,
  output logic                                 rd_valid,
  output logic [DATA_W-1:0]                    rd_data
);
  import cfc_pkg::*;

  localparam int BLK_W = $clog2(BLK_COLS);

  cfc_op_e           op;
  logic              accept;
  logic              acc_row, acc_blk, acc_fl, acc_load, acc_read;
  logic              sweep_on, sweep_blk, load_pend;
  logic [BLK_W-1:0]  sub;
  logic [DATA_W-1:0] color;
  logic [DATA_W-1:0] lane_en;
  logic [DATA_W-1:0] bit_en;

  logic [ROW_W-1:0]  row_q;
  logic [DATA_W-1:0] iomask_q, iomask_d;
  logic [DATA_W-1:0] cmask_q;
  logic              rdv_q;
  logic [DATA_W-1:0] rdd_q;

  assign op       = cfc_op_e'(req_op);
  assign busy     = sweep_on | load_pend;
  assign accept   = req_valid & ~busy;
  assign acc_row  = accept & (op == OP_ROW);
  assign acc_blk  = accept & (op == OP_BLOCK);
  assign acc_fl   = accept & (op == OP_FLASH);
  assign acc_load = accept & (op == OP_LOADC);
  assign acc_read = accept & (op == OP_READC);

  assign iomask_d = req_masked ? req_data : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q    <= '0;
      iomask_q <= '1;
    end else if (acc_row) begin
      row_q    <= req_row;
      iomask_q <= iomask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmask_q <= '0;
    end else if (acc_blk) begin
      cmask_q <= req_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdv_q <= 1'b0;
    end else begin
      rdv_q <= acc_read;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdd_q <= '0;
    end else if (acc_read) begin
      rdd_q <= color;
    end
  end

  cfc_color_reg #(.DATA_W(DATA_W)) u_color (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (acc_load),
    .cas_fall (cas_fall),
    .we_fall  (we_fall),
    .din      (req_data),
    .color    (color),
    .pending  (load_pend)
  );

  cfc_sweep #(.COL_W(COL_W), .BLK_W(BLK_W)) u_sweep (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_blk (acc_blk),
    .start_fl  (acc_fl),
    .grp       (req_col_grp),
    .active    (sweep_on),
    .is_blk    (sweep_blk),
    .col       (mem_col),
    .sub       (sub)
  );

  cfc_lane_mask #(.DATA_W(DATA_W), .BLK_COLS(BLK_COLS)) u_lane (
    .cmask   (cmask_q),
    .sel     (sub),
    .lane_en (lane_en)
  );

  always_comb begin
    bit_en = '0;
    if (sweep_on) begin
      bit_en = sweep_blk ? (iomask_q & lane_en) : iomask_q;
    end
  end

  assign mem_we     = |bit_en;
  assign mem_bit_en = bit_en;
  assign mem_row    = row_q;
  assign mem_wdata  = color;
  assign rd_valid   = rdv_q;
  assign rd_data    = rdd_q;
endmodule

// File: rtl/color_fill_chk.sv
module color_fill_chk #(
  parameter int ROW_W  = 9,
  parameter int COL_W  = 9,
  parameter int DATA_W = 16,
  parameter int BLK_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        req_op,
  input logic              busy,
  input logic              mem_we,
  input logic [ROW_W-1:0]  mem_row,
  input logic [COL_W-1:0]  mem_col,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              rd_valid,
  input logic              sweep_on,
  input logic              sweep_blk
);
  // R7: writes appear only inside a busy window
  a_r7_we_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R6: flash columns step by one per cycle
  a_r6_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_on && !sweep_blk && $past(sweep_on)) |-> (mem_col == $past(mem_col) + 1'b1));

  // R3: a block sweep stays in one column group
  a_r3_group_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_on && sweep_blk && $past(sweep_on)) |-> (mem_col[COL_W-1:BLK_W] == $past(mem_col[COL_W-1:BLK_W])));

  // R3: color data does not change inside a sweep
  a_r3_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_on && $past(sweep_on)) |-> $stable(mem_wdata));

  // R10: open row does not change inside a sweep
  a_r10_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_on && $past(sweep_on)) |-> $stable(mem_row));

  // R9: a read result follows an accepted read request
  a_r9_read_source: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && (req_op == 3'd5) && !busy));
endmodule

bind color_fill_ctrl color_fill_chk #(
  .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .BLK_W($clog2(BLK_COLS))
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .busy      (busy),
  .mem_we    (mem_we),
  .mem_row   (mem_row),
  .mem_col   (mem_col),
  .mem_wdata (mem_wdata),
  .rd_valid  (rd_valid),
  .sweep_on  (sweep_on),
  .sweep_blk (sweep_blk)
);

// File: tb/sim_color_fill_ctrl.sv
module sim_color_fill_ctrl;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_op;
  logic        req_masked;
  logic [8:0]  req_row;
  logic [5:0]  req_col_grp;
  logic [15:0] req_data;
  logic        cas_fall;
  logic        we_fall;
  logic        busy;
  logic        mem_we;
  logic [8:0]  mem_row;
  logic [8:0]  mem_col;
  logic [15:0] mem_wdata;
  logic [15:0] mem_bit_en;
  logic        rd_valid;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_color;
  logic [15:0] m_mask;
  logic [8:0]  m_row;

  color_fill_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_masked(req_masked), .req_row(req_row), .req_col_grp(req_col_grp),
    .req_data(req_data), .cas_fall(cas_fall), .we_fall(we_fall),
    .busy(busy), .mem_we(mem_we), .mem_row(mem_row), .mem_col(mem_col),
    .mem_wdata(mem_wdata), .mem_bit_en(mem_bit_en),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [15:0] blk_en(input logic [15:0] io, input logic [15:0] cm, input int k);
    return io & {{8{cm[8+k]}}, {8{cm[k]}}};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic msk, input logic [8:0] row,
                       input logic [5:0] grp, input logic [15:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_masked = msk;
    req_row = row; req_col_grp = grp; req_data = data;
    @(negedge clk);
    req_valid = 1'b0; req_data = 16'h0;
  endtask

  task automatic do_row(input logic msk, input logic [8:0] row, input logic [15:0] data);
    issue(3'd1, msk, row, 6'd0, data);
    m_row = row;
    m_mask = msk ? data : 16'hFFFF;
  endtask

  // block sweep with optional refused request at column 3
  task automatic do_block(input logic [5:0] grp, input logic [15:0] cm, input bit poke);
    logic [15:0] e;
    issue(3'd2, 1'b0, 9'd0, grp, cm);
    for (int k = 0; k < 8; k++) begin
      e = blk_en(m_mask, cm, k);
      chk("R3 R4 R5 block column", {mem_we, mem_row, mem_col, mem_wdata, mem_bit_en, busy},
          {|e, m_row, grp, 3'(k), m_color, e, 1'b1});
      if (poke && k == 3) begin
        req_valid = 1'b1; req_op = 3'd1; req_masked = 1'b1; req_row = ~m_row; req_data = 16'h0;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk("R7 busy after block", {63'd0, busy}, 64'd0);
  endtask

  task automatic do_flash(input bit poke);
    int bad = 0;
    issue(3'd3, 1'b0, 9'd0, 6'd0, 16'h0);
    for (int k = 0; k < 512; k++) begin
      if ({mem_we, mem_row, mem_col, mem_wdata, mem_bit_en, busy} !==
          {|m_mask, m_row, 9'(k), m_color, m_mask, 1'b1}) begin
        if (bad == 0)
          $display("FAIL R6 flash column %0d actual=%h expected=%h", k,
                   {mem_we, mem_row, mem_col, mem_wdata, mem_bit_en},
                   {|m_mask, m_row, 9'(k), m_color, m_mask});
        bad++;
      end
      if (poke && k == 100) begin
        req_valid = 1'b1; req_op = 3'd4;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
    checks++;
    if (bad != 0) errors++;
    chk("R7 busy after flash", {63'd0, busy}, 64'd0);
  endtask

  task automatic do_read(input string req);
    issue(3'd5, 1'b0, 9'd0, 6'd0, 16'h0);
    chk(req, {46'd0, rd_valid, mem_we, rd_data}, {46'd0, 1'b1, 1'b0, m_color});
    @(negedge clk);
    chk("R9 read pulse ends", {63'd0, rd_valid}, 64'd0);
  endtask

  // mode 0: cas then we, 1: we then cas, 2: same cycle
  task automatic do_load(input logic [15:0] val, input int mode, input int gap);
    issue(3'd4, 1'b0, 9'd0, 6'd0, 16'h0);
    req_data = ~val;
    if (mode == 2) begin
      cas_fall = 1'b1; we_fall = 1'b1; req_data = val;
    end else begin
      if (mode == 0) cas_fall = 1'b1; else we_fall = 1'b1;
      @(negedge clk);
      cas_fall = 1'b0; we_fall = 1'b0;
      for (int g = 0; g < gap; g++) begin
        chk("R8 busy while load pending", {62'd0, busy, mem_we}, {62'd0, 1'b1, 1'b0});
        @(negedge clk);
      end
      if (mode == 0) we_fall = 1'b1; else cas_fall = 1'b1;
      req_data = val;
    end
    @(negedge clk);
    cas_fall = 1'b0; we_fall = 1'b0; req_data = 16'h0;
    m_color = val;
    chk("R8 busy clears after later strobe", {63'd0, busy}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_valid = 1'b0; req_op = 3'd0; req_masked = 1'b0;
    req_row = '0; req_col_grp = '0; req_data = '0; cas_fall = 1'b0; we_fall = 1'b0;
    m_color = 16'hFFFF; m_mask = 16'hFFFF; m_row = 9'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", {61'd0, busy, mem_we, rd_valid}, 64'd0);
    do_read("R1 color reset value");
    do_flash(1'b0);                       // R1 mask reset ones
    do_load(16'hA5C3, 0, 2);              // R8 cas first
    do_read("R9 read after load");
    do_load(16'h1E78, 1, 0);              // R8 we first
    do_read("R8 we-first load");
    do_load(16'h0FF0, 2, 0);              // R8 same cycle
    do_read("R8 same-cycle load");
    do_row(1'b0, 9'd77, 16'h1234);        // R2 unmasked ignores data
    do_block(6'd5, 16'hFFFF, 1'b0);
    do_block(6'd63, 16'h00FF, 1'b0);      // R4 upper lane suppressed
    do_row(1'b1, 9'd300, 16'hF00F);       // R2 masked
    do_block(6'd0, 16'hA55A, 1'b1);       // R7 refused row request
    do_block(6'd9, 16'h0000, 1'b0);       // R5 no writes at all
    do_flash(1'b1);                       // R10 mask persists, R7 refused load
    do_read("R7 refused load left color");
    do_row(1'b1, 9'd12, 16'h0000);
    do_flash(1'b0);                       // R5 all-masked flash
    for (int i = 0; i < 24; i++) begin
      case ($urandom % 4)
        0: do_row(1'($urandom), 9'($urandom), 16'($urandom));
        1: do_block(6'($urandom), 16'($urandom), 1'($urandom));
        2: do_load(16'($urandom), int'($urandom % 3), int'($urandom % 4));
        default: do_read("R9 random read");
      endcase
    end
    do_row(1'b1, 9'($urandom), 16'($urandom));
    do_flash(1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule